// File: doc/BRIEF.md
# 64-bit Global Timer with Compare Event

The block keeps a 64-bit up-counter that advances by one on every clock while its run bit is set. A 32-bit register port exposes the counter as two independent halves, a 64-bit compare value (also as two halves), a 32-bit step value, a control word and a status word. Software may stop the counter, load either half, and start it again. The two halves are not captured together: a carry from the low word into the high word can land between two reads. Software gets a coherent value by reading high, then low, then high again, and repeating until the two high reads agree.

A comparator watches the count. While it is enabled and the count is at or above the compare value, a compare hit occurs. A hit moves the event state machine from `EV_QUIET` to `EV_RAISED`. Transitions: `EV_QUIET -> EV_RAISED` on a hit; `EV_RAISED -> EV_QUIET` on a status write of 1 with no hit in the same cycle; every other case holds the state. If the step mode is on, each hit also adds the step value to the compare value, so events repeat at a fixed period. The interrupt line is high while the machine is in `EV_RAISED` and the interrupt enable is set.

Register word map (byte offsets): 0x00 count low, 0x04 count high, 0x08 control, 0x0C status, 0x10 compare low, 0x14 compare high, 0x18 step value. Control bits: bit 0 run, bit 1 compare enable, bit 2 interrupt enable, bit 3 step mode. Status bit 0 is the event flag.

Top module: `tmr_global64`

## Requirements
- R1: After reset, every register (count, control, status, compare, step) reads 0 and `irq` is low.
- R2: With control bit 0 set, the count rises by exactly one per clock and a carry from bit 31 moves into the word at 0x04. With bit 0 clear, the count holds.
- R3: A write to 0x00 or 0x04 loads that half of the count on the next edge and leaves the other half unchanged. The count does not advance in that cycle. Counting resumes from the loaded value.
- R4: Reads of 0x00 and 0x04 return the live halves with no capture between them, so a high/low/high read sequence can observe a carry.
- R5: When control bit 1 is set and the count is greater than or equal to the 64-bit compare value {0x14, 0x10}, status bit 0 reads 1 from the next cycle on.
- R6: When control bit 3 is set, each cycle that has a compare hit adds the 32-bit step value (0x18, zero-extended) to the compare value. A write to either compare half in that cycle takes precedence.
- R7: Writing status with bit 0 = 1 clears the event flag. Writing bit 0 = 0 has no effect. A hit in the same cycle as a clear leaves the flag set.
- R8: `irq` is high exactly when the event flag is set and control bit 2 is set.
- R9: Control reads back its written bits 3:0 with zeros above, the step register reads back its full word, and a read of offset 0x1C or of a misaligned address returns 0. A write to a misaligned address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the word at `bus_addr` |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt, level high |

## Verification
The hardest case to reach is a status clear that arrives in the same cycle as a fresh compare hit. This needs the comparator enabled with the count sitting at or above the compare value while software writes the status word. The random stimulus keeps compare values within a few dozen counts of the live count. With step mode on and small step values, the compare value is then often already passed, so hits recur every cycle and collide with status clears. A separate directed run places the low word just below the 32-bit boundary and reads across the carry into the high word.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int unsigned DW = 32;

    // word index = byte address [4:2]
    typedef enum logic [2:0] {
        W_CLO  = 3'd0,
        W_CHI  = 3'd1,
        W_CTL  = 3'd2,
        W_STS  = 3'd3,
        W_MLO  = 3'd4,
        W_MHI  = 3'd5,
        W_STEP = 3'd6,
        W_NONE = 3'd7
    } word_e;

    typedef enum logic {
        EV_QUIET  = 1'b0,
        EV_RAISED = 1'b1
    } ev_state_e;

    typedef struct packed {
        logic step_mode;
        logic irq_en;
        logic cmp_en;
        logic run;
    } ctl_t;
endpackage

// File: rtl/tmr_count64.sv
module tmr_count64 #(
    parameter int HW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [HW-1:0]    ld_val,
    output logic [2*HW-1:0]  cnt
);
    localparam int CW = 2 * HW;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (ld_lo)
            cnt[HW-1:0] <= ld_val;
        else if (ld_hi)
            cnt[CW-1:HW] <= ld_val;
        else if (run)
            cnt <= cnt + {{(CW-1){1'b0}}, 1'b1};
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_lo && !ld_hi) |=> cnt == $past(cnt) + {{(CW-1){1'b0}}, 1'b1});

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_lo && !ld_hi) |=> $stable(cnt));

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (cnt[HW-1:0] == $past(ld_val)) && (cnt[CW-1:HW] == $past(cnt[CW-1:HW])));
endmodule

// File: rtl/tmr_match.sv
module tmr_match
    import tmr_pkg::*;
#(
    parameter int HW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*HW-1:0]  cnt,
    input  logic             cmp_en,
    input  logic             step_mode,
    input  logic [HW-1:0]    step_val,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [HW-1:0]    ld_val,
    input  logic             clr,
    output logic [2*HW-1:0]  cmp,
    output logic             flag
);
    localparam int CW = 2 * HW;

    ev_state_e state, state_nx;
    logic      hit;

    assign hit = cmp_en && (cnt >= cmp);

    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp <= '0;
        else if (ld_lo)
            cmp[HW-1:0] <= ld_val;
        else if (ld_hi)
            cmp[CW-1:HW] <= ld_val;
        else if (hit && step_mode)
            cmp <= cmp + {{HW{1'b0}}, step_val};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= EV_QUIET;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            EV_QUIET:  if (hit) state_nx = EV_RAISED;
            EV_RAISED: if (clr && !hit) state_nx = EV_QUIET;
            default:   state_nx = EV_QUIET;
        endcase
    end

    always_comb begin
        flag = 1'b0;
        unique case (state)
            EV_QUIET:  flag = 1'b0;
            EV_RAISED: flag = 1'b1;
            default:   flag = 1'b0;
        endcase
    end

    // R5
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && (cnt >= cmp)) |=> flag);

    // R7
    ev_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R6
    cmp_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && step_mode && !ld_lo && !ld_hi) |=> cmp == $past(cmp) + {{HW{1'b0}}, $past(step_val)});
endmodule

// File: rtl/tmr_global64.sv
module tmr_global64
    import tmr_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    localparam int HW = DW;
    localparam int CW = 2 * HW;

    ctl_t          ctl;
    logic [HW-1:0] step_q;
    logic [CW-1:0] cnt, cmp;
    logic          flag, aligned;
    word_e         widx;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign widx    = word_e'(bus_addr[4:2]);

    logic wr_clo, wr_chi, wr_ctl, wr_sts, wr_mlo, wr_mhi, wr_step;
    assign wr_clo  = bus_we && aligned && (widx == W_CLO);
    assign wr_chi  = bus_we && aligned && (widx == W_CHI);
    assign wr_ctl  = bus_we && aligned && (widx == W_CTL);
    assign wr_sts  = bus_we && aligned && (widx == W_STS);
    assign wr_mlo  = bus_we && aligned && (widx == W_MLO);
    assign wr_mhi  = bus_we && aligned && (widx == W_MHI);
    assign wr_step = bus_we && aligned && (widx == W_STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl    <= '0;
            step_q <= '0;
        end else begin
            if (wr_ctl)  ctl    <= ctl_t'(bus_wdata[3:0]);
            if (wr_step) step_q <= bus_wdata;
        end
    end

    tmr_count64 #(.HW(HW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctl.run),
        .ld_lo  (wr_clo),
        .ld_hi  (wr_chi),
        .ld_val (bus_wdata),
        .cnt    (cnt)
    );

    tmr_match #(.HW(HW)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt),
        .cmp_en    (ctl.cmp_en),
        .step_mode (ctl.step_mode),
        .step_val  (step_q),
        .ld_lo     (wr_mlo),
        .ld_hi     (wr_mhi),
        .ld_val    (bus_wdata),
        .clr       (wr_sts && bus_wdata[0]),
        .cmp       (cmp),
        .flag      (flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (widx)
                W_CLO:   bus_rdata = cnt[HW-1:0];
                W_CHI:   bus_rdata = cnt[CW-1:HW];
                W_CTL:   bus_rdata = {28'd0, ctl};
                W_STS:   bus_rdata = {31'd0, flag};
                W_MLO:   bus_rdata = cmp[HW-1:0];
                W_MHI:   bus_rdata = cmp[CW-1:HW];
                W_STEP:  bus_rdata = step_q;
                W_NONE:  bus_rdata = '0;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq = flag && ctl.irq_en;

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (u_match.state == EV_RAISED));

    // R9
    ctl_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> ctl == $past(bus_wdata[3:0]));
endmodule

// File: tb/sim_tmr_global64.sv
module sim_tmr_global64;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tmr_global64 u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference model built from the requirements
    logic [63:0] m_cnt, m_cmp;
    logic [3:0]  m_ctl;
    logic [31:0] m_step;
    logic        m_flag;

    always @(posedge clk) begin
        logic hit, al;
        logic [2:0] w;
        hit = m_ctl[1] && (m_cnt >= m_cmp);
        al  = (bus_addr[1:0] == 2'b00);
        w   = bus_addr[4:2];
        if (!rst_n) begin
            m_cnt <= '0; m_cmp <= '0; m_ctl <= '0; m_step <= '0; m_flag <= 1'b0;
        end else begin
            if (bus_we && al && w == 3'd0)      m_cnt[31:0]  <= bus_wdata;
            else if (bus_we && al && w == 3'd1) m_cnt[63:32] <= bus_wdata;
            else if (m_ctl[0])                  m_cnt <= m_cnt + 64'd1;
            if (bus_we && al && w == 3'd4)      m_cmp[31:0]  <= bus_wdata;
            else if (bus_we && al && w == 3'd5) m_cmp[63:32] <= bus_wdata;
            else if (hit && m_ctl[3])           m_cmp <= m_cmp + {32'd0, m_step};
            if (bus_we && al && w == 3'd2)      m_ctl  <= bus_wdata[3:0];
            if (bus_we && al && w == 3'd6)      m_step <= bus_wdata;
            if (hit) m_flag <= 1'b1;
            else if (bus_we && al && w == 3'd3 && bus_wdata[0]) m_flag <= 1'b0;
        end
    end

    function automatic logic [31:0] mread(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'd0;
        case (a[4:2])
            3'd0: return m_cnt[31:0];
            3'd1: return m_cnt[63:32];
            3'd2: return {28'd0, m_ctl};
            3'd3: return {31'd0, m_flag};
            3'd4: return m_cmp[31:0];
            3'd5: return m_cmp[63:32];
            3'd6: return m_step;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (a[1:0] != 2'b00) return "R9";
        case (a[4:2])
            3'd0: return "R2 R3";
            3'd1: return "R4 R3";
            3'd2: return "R9";
            3'd3: return "R5 R7";
            3'd4, 3'd5: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, compare state after the previous edge
    task automatic cyc(input logic we, input logic [4:0] a, input logic [31:0] d,
                       input string rtag);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        check((rtag.len() > 0) ? rtag : tag_of(a), bus_rdata, mread(a));
        check("R8 irq", {31'd0, irq}, {31'd0, m_flag && m_ctl[2]});
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, "");
    endtask

    task automatic rd(input logic [4:0] a);
        cyc(1'b0, a, 32'd0, "");
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values on every word
        for (int i = 0; i < 8; i++) cyc(1'b0, 5'(i * 4), 32'd0, "R1");

        // R3 load with counter stopped, then R2 counting resumes
        wr(5'h00, 32'hFFFF_FFFC);
        wr(5'h04, 32'h0000_0007);
        rd(5'h00); rd(5'h04);
        wr(5'h08, 32'h1);
        for (int i = 0; i < 6; i++) begin rd(5'h04); rd(5'h00); end  // R4 carry

        // R9 misaligned write ignored, unmapped read zero
        wr(5'h09, 32'hF);
        rd(5'h08); rd(5'h1C); rd(5'h0A);
        wr(5'h18, 32'hDEAD_BEEF); rd(5'h18);

        // R5 compare, R8 irq gating, R7 clear with 0 then 1
        wr(5'h08, 32'h1);
        wr(5'h00, 32'd0); wr(5'h04, 32'd0);
        wr(5'h10, 32'd10); wr(5'h14, 32'd0);
        wr(5'h08, 32'h3);
        for (int i = 0; i < 14; i++) rd(5'h0C);
        wr(5'h08, 32'h7); rd(5'h0C);
        wr(5'h0C, 32'h0); rd(5'h0C);
        wr(5'h08, 32'h5);
        wr(5'h0C, 32'h1); rd(5'h0C);
        // R7 clear colliding with a hit
        wr(5'h08, 32'h7);
        wr(5'h0C, 32'h1); rd(5'h0C);

        // R6 step mode
        wr(5'h18, 32'd5);
        wr(5'h10, 32'd0);
        wr(5'h08, 32'hF);
        for (int i = 0; i < 10; i++) begin rd(5'h10); rd(5'h0C); end

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 16;
            if (r < 5) begin
                int k;
                logic [31:0] d;
                k = $urandom % 8;
                case (k)
                    0: d = ($urandom % 4 == 0) ? 32'hFFFF_FFF0 : m_cnt[31:0] + ($urandom % 16);
                    1: d = m_cnt[63:32] + ($urandom % 2);
                    2: d = $urandom % 16;
                    3: d = $urandom % 2;
                    4: d = m_cnt[31:0] + ($urandom % 40);
                    5: d = m_cnt[63:32] + ($urandom % 2);
                    6: d = $urandom % 8;
                    default: d = $urandom;
                endcase
                wr(5'(k * 4 + (($urandom % 8 == 0) ? 1 : 0)), d);
            end else begin
                rd(5'($urandom % 32));
            end
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule